// File: doc/BRIEF.md
# March-Test RAM Self-Test Controller

This block is a built-in self-test engine placed next to a single-port synchronous RAM. While the system is in control, the RAM address, write data and write enable come straight from the system side, and the RAM read data is always returned to the system. A start pulse hands the RAM ports to the test. The test then applies a fixed seven-phase march, one RAM operation per clock. Five phases use all-zeros and all-ones words across the whole address range, going up or down. Two single-address phases walk a lone 0 and then a lone 1 across the word. Every read is compared one cycle later against the word that the sequence expects.

At the end of a run the controller raises a completion flag and shows a sticky fail flag. When a flag-check request is sampled together with start, the comparator inverts its expectations for that run. A fault-free RAM then has to drive the fail flag high, which shows that the flag can leave its passing value. The address width, the number of words and the word width are parameters.

Top module: `ram_march_bist`

## Requirements
- R1: While reset is asserted and after it is released, `bist_done` and `bist_fail` are 0, and the RAM ports follow the system inputs.
- R2: While no test is busy, `mem_addr`, `mem_wdata` and `mem_we` equal `sys_addr`, `sys_wdata` and `sys_we`. `sys_rdata` always equals `mem_rdata`.
- R3: `bist_start` is accepted only on a rising edge where the controller is idle or done. A start while a test is busy has no effect on the sequence or its length. `flag_check` is sampled on the accepting edge.
- R4: The test is busy from the cycle after the accepting edge through the cycle after its last operation. During that time the test alone drives the RAM ports, the system inputs are ignored, and no write is issued in the final cycle.
- R5: Operation k of the sequence (k = 0, 1, ...) is on the RAM ports in the k-th cycle after the accepting edge. The phases are: (1) ascending write 0; (2) ascending read 0, write 1, write 0, write 1; (3) ascending read 1, write 0, read 0, write 1; (4) descending from WORDS-1 to 0: read 1, write 0, write 1, write 0; (5) descending read 0, write 1, read 1, write 0. Here "0" and "1" mean the all-zeros and all-ones words.
- R6: Phase 6 and phase 7 use address 0 only. For b = 0 up to DATA_W-1, each writes a pattern and reads it back in the next cycle. In phase 6 the pattern is all ones except bit b (bit b has weight 2^b). In phase 7 it is only bit b set.
- R7: The read data of each read is compared in the following cycle. A mismatch sets `bist_fail`, and `bist_fail` stays set until the next accepted start clears it.
- R8: With L = 17*WORDS + 4*DATA_W, `bist_done` is 0 after L rising edges that follow the accepting edge and is 1 after L+1. It stays 1 until the next accepted start.
- R9: When `flag_check` is 1 at the accepting edge, every expected word is inverted for that run, so a fault-free RAM ends with `bist_fail` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_start | input | 1 | Request to begin a self-test run |
| flag_check | input | 1 | Run with inverted expectations to prove the fail flag |
| bist_done | output | 1 | Run finished; held until next start |
| bist_fail | output | 1 | Sticky mismatch flag |
| sys_addr | input | ADDR_W | System-side address |
| sys_wdata | input | DATA_W | System-side write data |
| sys_we | input | 1 | System-side write enable |
| sys_rdata | output | DATA_W | RAM read data returned to the system |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_wdata | output | DATA_W | Write data to the RAM |
| mem_we | output | 1 | Write enable to the RAM |
| mem_rdata | input | DATA_W | Registered read data from the RAM |

## Verification
The bench runs the march against a RAM model in several states. In a clean RAM every read must pass. A cell stuck at 0 near the middle of the array can only be caught by the all-ones reads. A cell stuck at 1 at the top address is caught by the all-zeros reads. An intra-word coupling at address 0 is missed by the solid words and caught only by the walking phases. The same coupling at another address must go undetected, which shows that the walking phases stay on one address. A clean RAM run in flag-check mode, a start issued mid-run, and runs where the system inputs are held at hostile values show that the fail flag can be driven, that a start while busy is ignored, and that the system side is locked out. In every run the bench compares each cycle's RAM port values with an operation list it builds itself.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } bist_state_e;

  // one march operation: read or write, and whether the word is all ones
  typedef struct packed {
    logic rd;
    logic one;
  } march_op_t;

  // operations of the solid-word phases (phase index 0..4)
  function automatic march_op_t march_op(input logic [2:0] phase, input logic [1:0] step);
    march_op_t o;
    o = '{rd: 1'b0, one: 1'b0};
    case (phase)
      3'd1: case (step)
        2'd0: o = '{rd: 1'b1, one: 1'b0};
        2'd1: o = '{rd: 1'b0, one: 1'b1};
        2'd2: o = '{rd: 1'b0, one: 1'b0};
        default: o = '{rd: 1'b0, one: 1'b1};
      endcase
      3'd2: case (step)
        2'd0: o = '{rd: 1'b1, one: 1'b1};
        2'd1: o = '{rd: 1'b0, one: 1'b0};
        2'd2: o = '{rd: 1'b1, one: 1'b0};
        default: o = '{rd: 1'b0, one: 1'b1};
      endcase
      3'd3: case (step)
        2'd0: o = '{rd: 1'b1, one: 1'b1};
        2'd1: o = '{rd: 1'b0, one: 1'b0};
        2'd2: o = '{rd: 1'b0, one: 1'b1};
        default: o = '{rd: 1'b0, one: 1'b0};
      endcase
      3'd4: case (step)
        2'd0: o = '{rd: 1'b1, one: 1'b0};
        2'd1: o = '{rd: 1'b0, one: 1'b1};
        2'd2: o = '{rd: 1'b1, one: 1'b1};
        default: o = '{rd: 1'b0, one: 1'b0};
      endcase
      default: o = '{rd: 1'b0, one: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORDS  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              start_acc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              rd_o
);

  localparam int                BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(WORDS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [2:0]        PH_WALK0 = 3'd5;
  localparam logic [2:0]        PH_WALK1 = 3'd6;

  bist_state_e       state_q, state_d;
  logic [2:0]        phase_q, phase_d;
  logic [1:0]        step_q, step_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  march_op_t         solid_op;
  logic              walking, descending, rd_now, last_step, addr_end;
  logic [DATA_W-1:0] single_one, pattern;

  // operation decode
  always_comb begin
    solid_op   = march_op(phase_q, step_q);
    walking    = (phase_q >= PH_WALK0);
    descending = (phase_q == 3'd3) || (phase_q == 3'd4);
    single_one = DATA_W'(1) << bit_q;
    if (walking) begin
      rd_now  = step_q[0];
      pattern = (phase_q == PH_WALK0) ? ~single_one : single_one;
    end else begin
      rd_now  = solid_op.rd;
      pattern = {DATA_W{solid_op.one}};
    end
    if (phase_q == 3'd0)  last_step = 1'b1;
    else if (walking)     last_step = step_q[0];
    else                  last_step = (step_q == 2'd3);
    addr_end = descending ? (addr_q == '0) : (addr_q == TOP_ADDR);
  end

  assign start_acc_o = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // next-state logic
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    step_d  = step_q;
    addr_d  = addr_q;
    bit_d   = bit_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          phase_d = 3'd0;
          step_d  = 2'd0;
          addr_d  = '0;
          bit_d   = '0;
        end
      end
      ST_RUN: begin
        if (!last_step) begin
          step_d = step_q + 2'd1;
        end else begin
          step_d = 2'd0;
          if (!walking) begin
            if (!addr_end) begin
              addr_d = descending ? (addr_q - ADDR_W'(1)) : (addr_q + ADDR_W'(1));
            end else begin
              phase_d = phase_q + 3'd1;
              if ((phase_q == 3'd2) || (phase_q == 3'd3)) addr_d = TOP_ADDR;
              else                                          addr_d = '0;
            end
          end else if (bit_q != LAST_BIT) begin
            bit_d = bit_q + BIT_W'(1);
          end else if (phase_q == PH_WALK0) begin
            phase_d = PH_WALK1;
            bit_d   = '0;
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 3'd0;
      step_q  <= 2'd0;
      addr_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      addr_q  <= addr_d;
      bit_q   <= bit_d;
    end
  end

  assign busy_o  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done_o  = (state_q == ST_DONE);
  assign addr_o  = addr_q;
  assign wdata_o = pattern;
  assign we_o    = (state_q == ST_RUN) && !rd_now;
  assign rd_o    = (state_q == ST_RUN) && rd_now;

  // R5: the address counter stays inside the populated range
  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (addr_q <= TOP_ADDR));

  // R5: phases only advance during a run
  p_phase_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && ($past(state_q) == ST_RUN)) |-> (phase_q >= $past(phase_q)));

  // R6: walking phases stay on address 0
  p_walk_addr0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && walking) |-> (addr_q == '0));

  // R8: drain lasts exactly one cycle before done
  p_drain_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |=> (state_q == ST_DONE));

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              invert_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o
);

  logic              chk_q, chk_d;
  logic [DATA_W-1:0] exp_q, exp_d;
  logic              inv_q, inv_d;
  logic              fail_q, fail_d;
  logic              mismatch;

  always_comb begin
    mismatch = (rdata_i != (exp_q ^ {DATA_W{inv_q}}));
    chk_d    = rd_i;
    exp_d    = rd_i ? expect_i : exp_q;
    inv_d    = clear_i ? invert_i : inv_q;
    if (clear_i)                fail_d = 1'b0;
    else if (chk_q && mismatch) fail_d = 1'b1;
    else                        fail_d = fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      exp_q  <= '0;
      inv_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      chk_q  <= chk_d;
      exp_q  <= exp_d;
      inv_q  <= inv_d;
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

  // R7: the flag holds until a clearing start
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear_i) |=> fail_q);

  // R7: the flag only rises from a compare slot
  p_fail_from_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(chk_q));

endmodule

// File: rtl/ram_march_bist.sv
module ram_march_bist #(
  parameter int ADDR_W = 4,
  parameter int WORDS  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_start,
  input  logic              flag_check,
  output logic              bist_done,
  output logic              bist_fail,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [DATA_W-1:0] sys_wdata,
  input  logic              sys_we,
  output logic [DATA_W-1:0] sys_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              start_acc, busy, t_we, t_rd;
  logic [ADDR_W-1:0] t_addr;
  logic [DATA_W-1:0] t_wdata;

  march_seq #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (bist_start),
    .start_acc_o (start_acc),
    .busy_o      (busy),
    .done_o      (bist_done),
    .addr_o      (t_addr),
    .wdata_o     (t_wdata),
    .we_o        (t_we),
    .rd_o        (t_rd)
  );

  march_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_acc),
    .invert_i (flag_check),
    .rd_i     (t_rd),
    .expect_i (t_wdata),
    .rdata_i  (mem_rdata),
    .fail_o   (bist_fail)
  );

  // port multiplexers
  always_comb begin
    if (busy) begin
      mem_addr  = t_addr;
      mem_wdata = t_wdata;
      mem_we    = t_we;
    end else begin
      mem_addr  = sys_addr;
      mem_wdata = sys_wdata;
      mem_we    = sys_we;
    end
  end

  assign sys_rdata = mem_rdata;

  // R2: no write reaches the RAM when neither side asks for one
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sys_we) |-> !mem_we);

  // R8: completion holds until a new start
  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_done && !bist_start) |=> bist_done);

  // R3: a start never clears the fail flag while busy
  p_busy_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bist_fail) |=> bist_fail);

endmodule

// File: tb/test_ram_march_bist.sv
module test_ram_march_bist;

  localparam int AW = 4;
  localparam int NW = 16;
  localparam int DW = 8;
  localparam int L  = 17 * NW + 4 * DW;

  logic          clk, rst_n, bist_start, flag_check, bist_done, bist_fail, sys_we, mem_we;
  logic [AW-1:0] sys_addr, mem_addr;
  logic [DW-1:0] sys_wdata, sys_rdata, mem_wdata, mem_rdata;

  ram_march_bist #(.ADDR_W(AW), .WORDS(NW), .DATA_W(DW)) i_ram_march_bist (
    .clk(clk), .rst_n(rst_n), .bist_start(bist_start), .flag_check(flag_check),
    .bist_done(bist_done), .bist_fail(bist_fail),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we), .sys_rdata(sys_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural RAM with one injectable fault (kind 1 stuck bit, kind 2 coupling to bit+1)
  logic [DW-1:0] ram [NW];
  logic [1:0]    f_kind;
  logic [AW-1:0] f_addr;
  logic [2:0]    f_bit;
  logic          f_val;

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    if (a == f_addr) begin
      if (f_kind == 2'd1) r[f_bit] = f_val;
      if (f_kind == 2'd2 && f_bit < 3'(DW - 1)) r[f_bit + 3'd1] = d[f_bit];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= faulty(mem_addr, mem_wdata);
    mem_rdata <= ram[mem_addr];
  end

  // expected operation list
  logic          e_we   [L];
  logic [AW-1:0] e_addr [L];
  logic [DW-1:0] e_data [L];

  task automatic build_list();
    int i;
    i = 0;
    for (int a = 0; a < NW; a++) begin
      e_we[i] = 1; e_addr[i] = AW'(a); e_data[i] = '0; i++;
    end
    for (int ph = 1; ph <= 4; ph++) begin
      for (int s = 0; s < NW; s++) begin
        int a;
        logic [3:0] rd;
        logic [3:0] one;
        a = (ph >= 3) ? (NW - 1 - s) : s;
        case (ph)
          1: begin rd = 4'b0001; one = 4'b1010; end
          2: begin rd = 4'b0101; one = 4'b1001; end
          3: begin rd = 4'b0001; one = 4'b0101; end
          default: begin rd = 4'b0101; one = 4'b0110; end
        endcase
        for (int k = 0; k < 4; k++) begin
          e_we[i] = !rd[k]; e_addr[i] = AW'(a); e_data[i] = {DW{one[k]}}; i++;
        end
      end
    end
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < DW; b++) begin
        logic [DW-1:0] p;
        p = '0;
        p[b] = 1'b1;
        if (w == 0) p = ~p;
        e_we[i] = 1; e_addr[i] = '0; e_data[i] = p; i++;
        e_we[i] = 0; e_addr[i] = '0; e_data[i] = p; i++;
      end
    end
  endtask

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_bist(input logic fc, input logic exp_fail, input bit mid_start);
    int bad_k;
    bad_k = -1;
    @(negedge clk);
    bist_start = 1; flag_check = fc;
    sys_we = 1; sys_addr = 4'h9; sys_wdata = 8'hA5;
    @(negedge clk);
    bist_start = 0; flag_check = 0;
    chk(!bist_fail && !bist_done, "R7 start clears flags", {bist_done, bist_fail}, 0);
    for (int k = 0; k < L; k++) begin
      if (mem_we !== e_we[k] || mem_addr !== e_addr[k] || (e_we[k] && mem_wdata !== e_data[k]))
        if (bad_k < 0) bad_k = k;
      if (mid_start && k == 40) bist_start = 1;
      if (mid_start && k == 41) bist_start = 0;
      @(negedge clk);
    end
    chk(bad_k < 0, "R4/R5/R6 operation stream", bad_k, 32'hFFFFFFFF);
    chk(!bist_done && !mem_we, "R8/R4 drain cycle", {bist_done, mem_we}, 0);
    sys_we = 0;
    @(negedge clk);
    chk(bist_done === 1'b1, "R8 done after L+1 edges", bist_done, 1);
    chk(bist_fail === exp_fail, "R7/R9 fail result", bist_fail, exp_fail);
    repeat (3) @(negedge clk);
    chk(bist_done && bist_fail === exp_fail, "R7/R8 flags held", {bist_done, bist_fail}, {1'b1, exp_fail});
  endtask

  // scenario vectors: [11:10] fault kind, [9:6] addr, [5:3] bit, [2] stuck value, [1] flag_check, [0] expected fail
  localparam logic [11:0] VEC [0:5] = '{
    12'b00_0000_000_0_0_0,
    12'b01_0101_011_0_0_1,
    12'b01_1111_111_1_0_1,
    12'b00_0000_000_0_1_1,
    12'b10_0000_010_0_0_1,
    12'b10_0011_010_0_0_0
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bist_start = 0; flag_check = 0;
    sys_we = 0; sys_addr = 4'h3; sys_wdata = 8'h5A;
    f_kind = 0; f_addr = 0; f_bit = 0; f_val = 0;
    build_list();
    repeat (3) @(negedge clk);
    chk(!bist_done && !bist_fail, "R1 flags in reset", {bist_done, bist_fail}, 0);
    chk(mem_addr == sys_addr && mem_wdata == sys_wdata && !mem_we, "R1 ports in reset",
        {mem_addr, mem_wdata, mem_we}, {sys_addr, sys_wdata, 1'b0});
    rst_n = 1;
    @(negedge clk);
    chk(!bist_done && !bist_fail, "R1 flags after reset", {bist_done, bist_fail}, 0);

    // R2: system access while idle, including read return
    sys_addr = 4'h7; sys_wdata = 8'hC3; sys_we = 1;
    #1;
    chk(mem_addr == 4'h7 && mem_wdata == 8'hC3 && mem_we, "R2 idle pass-through",
        {mem_addr, mem_wdata, mem_we}, {4'h7, 8'hC3, 1'b1});
    @(negedge clk);
    sys_we = 0;
    @(negedge clk);
    chk(sys_rdata == 8'hC3, "R2 read return", sys_rdata, 8'hC3);

    foreach (VEC[i]) begin
      f_kind = VEC[i][11:10]; f_addr = VEC[i][9:6]; f_bit = VEC[i][5:3]; f_val = VEC[i][2];
      run_bist(VEC[i][1], VEC[i][0], 0);
    end

    // R3: start while busy is ignored; run length and result unchanged
    f_kind = 0;
    run_bist(0, 0, 1);

    // R2 after done: pass-through again, no stray writes
    sys_addr = 4'hE; sys_wdata = 8'h3C; sys_we = 0;
    #1;
    chk(mem_addr == 4'hE && mem_wdata == 8'h3C && !mem_we, "R2 pass-through when done",
        {mem_addr, mem_wdata, mem_we}, {4'hE, 8'h3C, 1'b0});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule